// File: doc/BRIEF.md
# Dual-Polynomial Bit Scrambler

This block whitens a serial bit stream. Each accepted input bit is XORed with the feedback bit of a linear feedback shift register. The result leaves the block one clock later. Software picks one of two generators: a short 6-stage register with taps for x^6 + x^5 + 1, or a long 15-stage register with taps for x^15 + x^14 + 1. Each generator starts from a programmable seed.

A frame-start strobe loads the seed and the generator choice, so every frame begins from a known state. Settings changed in the middle of a frame wait for the next strobe. The enable input can be dropped to bypass the scrambling. The data still leaves one cycle later, and the register keeps stepping, so the stream stays aligned.

Descrambling is the same operation. A second instance, started on the same frame boundary with the same settings, restores the original bits.

Top module: `rnd_scrambler`

## Requirements
- R1: In short mode (cfg_poly_long=0) the register uses stages 0..5 and the feedback is stage5 XOR stage4. Each accepted bit shifts the stages toward higher index, with the feedback entering stage 0. Stages 6..14 stay zero.
- R2: In long mode (cfg_poly_long=1) the register uses stages 0..14 and the feedback is stage14 XOR stage13. It shifts the same way.
- R3: A frame_start strobe loads cfg_seed, bit i into stage i (bits 0..5 only in short mode), and latches cfg_poly_long. A bit accepted in the same cycle is scrambled with the freshly loaded state.
- R4: A seed whose used bits are all zero is loaded as all ones in the used stages, so the register is never all zero.
- R5: With cfg_enable=0 the output bit equals the input bit. The register still steps for each accepted bit.
- R6: out_valid equals in_valid delayed by one clock, and out_bit carries the result for that bit.
- R7: Changes to cfg_seed or cfg_poly_long without a frame_start do not alter the running sequence.
- R8: The register steps only on cycles with in_valid=1. Idle cycles leave it unchanged.
- R9: After reset out_valid=0 and out_bit=0, and the register holds all ones in short mode until the first frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | 1 = scramble, 0 = pass through |
| cfg_poly_long | input | 1 | 0 = 6-stage generator, 1 = 15-stage generator |
| cfg_seed | input | 15 | Seed for the register; the low 6 bits are used in short mode |
| frame_start | input | 1 | Loads seed and generator choice before this cycle's bit |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Serial input data |
| out_valid | output | 1 | Output bit is valid |
| out_bit | output | 1 | Serial output data |

## Verification
A wrong register state, such as a bad tap, a bad load or an unwanted step, shows up as a wrong out_bit on the very next accepted bit. The sequence then stays out of phase until the next frame_start. An all-zero lock-up shows as scrambled output equal to the input for the rest of the frame. A generator choice taken mid-frame shows up within a few bits, because the two sequences soon differ. The bench models the register from the tap rules and compares every valid output bit, across random gaps, strobes and settings changes.

// File: rtl/rnd_pkg.sv
`timescale 1ns/1ps
package rnd_pkg;
    typedef enum logic {POLY_SHORT = 1'b0, POLY_LONG = 1'b1} poly_e;
    localparam int SHORT_LEN = 6;
    localparam int SHORT_TAP = 5;
    localparam int LONG_LEN  = 15;
    localparam int LONG_TAP  = 14;
endpackage

// File: rtl/rnd_seed_fix.sv
`timescale 1ns/1ps
module rnd_seed_fix
    import rnd_pkg::*;
#(
    parameter int SHORT_LEN = rnd_pkg::SHORT_LEN,
    parameter int LONG_LEN  = rnd_pkg::LONG_LEN
) (
    input  poly_e               sel,
    input  logic [LONG_LEN-1:0] seed,
    output logic [LONG_LEN-1:0] fixed
);
    localparam logic [LONG_LEN-1:0] MASK_S = LONG_LEN'((1 << SHORT_LEN) - 1);
    localparam logic [LONG_LEN-1:0] MASK_L = '1;

    logic [LONG_LEN-1:0] mask;
    logic [LONG_LEN-1:0] used;

    always_comb begin
        mask  = (sel == POLY_LONG) ? MASK_L : MASK_S;
        used  = seed & mask;
        fixed = (used == '0) ? mask : used;
    end

    always_comb begin
        assert (fixed != '0) else $error("p_seed_nonzero_r4");
    end
endmodule

// File: rtl/rnd_lfsr.sv
`timescale 1ns/1ps
module rnd_lfsr
    import rnd_pkg::*;
#(
    parameter int SHORT_LEN = rnd_pkg::SHORT_LEN,
    parameter int SHORT_TAP = rnd_pkg::SHORT_TAP,
    parameter int LONG_LEN  = rnd_pkg::LONG_LEN,
    parameter int LONG_TAP  = rnd_pkg::LONG_TAP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  poly_e               load_sel,
    input  logic [LONG_LEN-1:0] load_val,
    input  logic                step,
    output logic                fb
);
    localparam int W = LONG_LEN;
    localparam logic [W-1:0] MASK_S = W'((1 << SHORT_LEN) - 1);
    localparam logic [W-1:0] MASK_L = '1;

    typedef struct packed {
        logic [W-1:0] st;
        poly_e        sel;
    } lfsr_t;

    lfsr_t d, q;
    logic [W-1:0] cur_st;
    poly_e        cur_sel;

    always_comb begin
        cur_st  = load ? load_val : q.st;
        cur_sel = load ? load_sel : q.sel;
        if (cur_sel == POLY_LONG)
            fb = cur_st[LONG_LEN-1] ^ cur_st[LONG_TAP-1];
        else
            fb = cur_st[SHORT_LEN-1] ^ cur_st[SHORT_TAP-1];
        d.sel = cur_sel;
        d.st  = cur_st;
        if (step)
            d.st = {cur_st[W-2:0], fb} & ((cur_sel == POLY_LONG) ? MASK_L : MASK_S);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= MASK_S;
            q.sel <= POLY_SHORT;
        end else begin
            q <= d;
        end
    end

    p_state_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.st != '0);
    p_short_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel == POLY_SHORT) |-> ((q.st & ~MASK_S) == '0));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(q.st));
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q.sel));
endmodule

// File: rtl/rnd_scrambler.sv
`timescale 1ns/1ps
module rnd_scrambler
    import rnd_pkg::*;
#(
    parameter int SHORT_LEN = rnd_pkg::SHORT_LEN,
    parameter int SHORT_TAP = rnd_pkg::SHORT_TAP,
    parameter int LONG_LEN  = rnd_pkg::LONG_LEN,
    parameter int LONG_TAP  = rnd_pkg::LONG_TAP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic                cfg_poly_long,
    input  logic [LONG_LEN-1:0] cfg_seed,
    input  logic                frame_start,
    input  logic                in_valid,
    input  logic                in_bit,
    output logic                out_valid,
    output logic                out_bit
);
    typedef struct packed {
        logic vld;
        logic dat;
    } out_t;

    out_t d, q;
    poly_e               sel_in;
    logic [LONG_LEN-1:0] seed_fixed;
    logic                fb;

    assign sel_in = poly_e'(cfg_poly_long);

    rnd_seed_fix #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_seed (
        .sel   (sel_in),
        .seed  (cfg_seed),
        .fixed (seed_fixed)
    );

    rnd_lfsr #(
        .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP),
        .LONG_LEN(LONG_LEN),   .LONG_TAP(LONG_TAP)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_start),
        .load_sel (sel_in),
        .load_val (seed_fixed),
        .step     (in_valid),
        .fb       (fb)
    );

    always_comb begin
        d.vld = in_valid;
        d.dat = q.dat;
        if (in_valid)
            d.dat = cfg_enable ? (in_bit ^ fb) : in_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.vld;
    assign out_bit   = q.dat;

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_enable) |=> (out_bit == $past(in_bit)));
endmodule

// File: tb/tb_rnd_scrambler.sv
`timescale 1ns/1ps
module tb_rnd_scrambler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic        cfg_poly_long = 1'b0;
    logic [14:0] cfg_seed = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        out_valid;
    logic        out_bit;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [14:0] m_st = 15'h003f;
    logic        m_long = 1'b0;

    always #2.5 clk = ~clk;

    rnd_scrambler dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_poly_long(cfg_poly_long), .cfg_seed(cfg_seed),
        .frame_start(frame_start), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    function automatic logic [14:0] mask_of(logic lng);
        return lng ? 15'h7fff : 15'h003f;
    endfunction

    function automatic logic fb_of(logic [14:0] s, logic lng);
        return lng ? (s[14] ^ s[13]) : (s[5] ^ s[4]);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic fs, input logic v, input logic b, input string req);
        logic f;
        logic e;
        @(negedge clk);
        frame_start = fs;
        in_valid    = v;
        in_bit      = b;
        if (fs) begin
            m_long = cfg_poly_long;
            m_st   = cfg_seed & mask_of(m_long);
            if (m_st == '0) m_st = mask_of(m_long);
        end
        f = fb_of(m_st, m_long);
        e = cfg_enable ? (b ^ f) : b;
        if (v) m_st = {m_st[13:0], f} & mask_of(m_long);
        @(posedge clk);
        #1;
        check(out_valid, v, req);
        if (v) check(out_bit, e, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid, 1'b0, "R9 reset valid");
        check(out_bit, 1'b0, "R9 reset bit");
        @(negedge clk);
        rst_n = 1'b1;
        // R9: all-ones short-mode state after reset, no strobe yet
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, "R9 post-reset sequence");
        // R1: short generator from a one-hot seed
        cfg_seed = 15'h0001; cfg_poly_long = 1'b0;
        step(1'b1, 1'b1, 1'b0, "R3 same-cycle load");
        for (int i = 0; i < 70; i++) step(1'b0, 1'b1, 1'b0, "R1 short sequence");
        // R2: long generator
        cfg_seed = 15'h4a31; cfg_poly_long = 1'b1;
        step(1'b1, 1'b1, 1'b1, "R3 long load");
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, 1'($urandom_range(0, 1)), "R2 long sequence");
        // R4: zero seeds in both modes
        cfg_seed = 15'h0000; cfg_poly_long = 1'b1;
        step(1'b1, 1'b1, 1'b0, "R4 zero seed long");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, "R4 zero seed long");
        cfg_seed = 15'h7fc0; cfg_poly_long = 1'b0;
        step(1'b1, 1'b1, 1'b0, "R4 zero used bits short");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, "R4 zero used bits short");
        // R7: mid-frame changes ignored
        cfg_seed = 15'h1234; cfg_poly_long = 1'b0;
        step(1'b1, 1'b1, 1'b1, "R3 frame");
        cfg_seed = 15'h0f0f; cfg_poly_long = 1'b1;
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, "R7 mid-frame change");
        // R8: idle gaps
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'b0, 1'b1, "R8 idle");
            step(1'b0, 1'b1, 1'b0, "R8 after gap");
        end
        // R5: bypass keeps stepping
        cfg_enable = 1'b0;
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'($urandom_range(0, 1)), "R5 bypass");
        cfg_enable = 1'b1;
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b0, "R5 resume alignment");
        // R6 and mix: constrained random
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 3000; i++) begin
            logic fs;
            if ($urandom_range(0, 31) == 0) cfg_seed = 15'($urandom());
            if ($urandom_range(0, 31) == 0) cfg_poly_long = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 63) == 0) cfg_enable = ~cfg_enable;
            fs = ($urandom_range(0, 15) == 0);
            step(fs, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), "R6 random mix");
        end
        step(1'b0, 1'b0, 1'b0, "R6 final idle");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule